// File: doc/BRIEF.md
# Host Bus Snoop Controller

This block sits on the host side of a system controller. It keeps the processor's first-level cache coherent while a PCI bus master reads or writes DRAM. A PCI initiator request arrives on a valid/ready stream with its direction, burst length and a peer-transfer flag. For a DRAM request the block holds the processor's address bus and probes the cache with a one-cycle strobe. The strobe carries an invalidate hint that follows the access direction. The block then samples the hit-modified reply. If the line is dirty, it waits for the writeback to finish before granting the PCI access with a one-cycle pulse. The hold stays up for the whole burst.

Peer-to-peer requests skip the snoop and never raise the hold. A locked processor sequence closes the request stream, and so does an active hold-acknowledge window from the I/O bridge. That window also forces the address hold high for its whole duration. Back-pressure rule: `req_ready` does not depend on `req_valid` or on the request fields. A request is taken on any clock edge where both are high. The fields only need to be stable in that cycle, and they are captured there. No new request is taken until the previous burst has completed.

Top module: `host_snoop_ctrl`

## Requirements
- R1: `req_ready` is high only when no request is in flight, no processor lock is in force and `bridge_hold` is low. A request is accepted on an edge where `req_valid` and `req_ready` are both high, and `req_ready` is low from the next cycle until the burst completes.
- R2: For a DRAM request (`req_peer`=0), `ahold` is high from the cycle after acceptance up to and including the cycle of the last counted beat. It is low after that edge, unless `bridge_hold` is high.
- R3: For a peer request (`req_peer`=1), `ahold` stays low (unless `bridge_hold` is high), no strobe is issued, and `grant` pulses in the first cycle after acceptance.
- R4: While `bridge_hold` is high, `ahold` is high and `req_ready` is low in the same cycle.
- R5: Each DRAM request produces exactly one `eads` pulse, one cycle wide, in the second cycle after acceptance, while `ahold` is high.
- R6: While `eads` is high, `inv_hint` equals the accepted `req_write` (1 = write snoop, 0 = read snoop). `inv_hint` is low in every other cycle.
- R7: `cpu_hitm` is sampled only in the cycle two cycles after the `eads` cycle. If it is high, `grant` waits for a `wb_done` pulse and rises in the cycle after it. If it is low, `grant` pulses in the fifth cycle after acceptance.
- R8: `grant` is one cycle wide per accepted request.
- R9: Once `cpu_ads` and `cpu_lock` are seen high together, `req_ready` is low in that cycle and stays low until `cpu_lock` falls. `cpu_lock` alone, without `cpu_ads`, does not block requests.
- R10: `boff` is high only in the first cycle after a DRAM request is accepted, and only if `cpu_busy` is high in that cycle.
- R11: `req_len` holds the number of beats minus one. The burst completes on the edge where the (`req_len`+1)-th `pci_beat` is counted. Beats count only in the cycles after the `grant` cycle.
- R12: After reset, `ahold`, `eads`, `boff`, `inv_hint` and `grant` are low and `req_ready` is high while the inputs are quiet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | PCI initiator request valid |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = DRAM write, 0 = DRAM read |
| req_len | input | LEN_W | Burst beats minus one |
| req_peer | input | 1 | Peer-to-peer transfer, no snoop |
| grant | output | 1 | One-cycle access grant |
| pci_beat | input | 1 | One data beat of the granted burst |
| bridge_hold | input | 1 | Hold-acknowledge from the I/O bridge |
| cpu_ads | input | 1 | Processor address strobe |
| cpu_lock | input | 1 | Processor locked sequence |
| cpu_busy | input | 1 | Processor cycle in progress |
| cpu_hitm | input | 1 | Hit-modified reply from the cache |
| wb_done | input | 1 | Modified-line writeback finished |
| ahold | output | 1 | Address hold to the processor |
| eads | output | 1 | External address strobe, cache probe |
| boff | output | 1 | Back-off to the processor |
| inv_hint | output | 1 | Invalidate hint during the probe |

## Verification
The assertions assume that `cpu_hitm` is only meaningful in the sampling cycle two cycles after the strobe, and that `wb_done` is pulsed only after a dirty reply. The bench drives `cpu_hitm` only in that sampling cycle and raises `wb_done` only while a writeback is awaited. The bench sends `pci_beat` only after the grant and keeps `req_valid` low whenever it drives a lock or bridge window it does not want accepted. Random transfers mix direction, length, peer flag, dirty replies, writeback delay and beat gaps.

// File: rtl/snp_pkg.sv
package snp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_PROBE,
    ST_GAP,
    ST_SAMPLE,
    ST_WBWAIT,
    ST_GRANT,
    ST_XFER
  } snp_state_e;
endpackage

// File: rtl/snp_lock_guard.sv
module snp_lock_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_ads,
  input  logic cpu_lock,
  output logic lock_block
);
  logic lk_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        lk_q <= 1'b0;
    else if (!cpu_lock) lk_q <= 1'b0;
    else if (cpu_ads)   lk_q <= 1'b1;
  end

  // blocking starts in the strobe cycle itself and ends as soon as lock drops
  assign lock_block = cpu_lock & (lk_q | cpu_ads);
endmodule

// File: rtl/snp_beat_count.sv
module snp_beat_count #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] len,
  input  logic             en,
  input  logic             beat,
  output logic             done
);
  localparam int CNT_W = LEN_W;

  logic [CNT_W-1:0] cnt_q;
  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      len_q <= '0;
    end else if (load) begin
      cnt_q <= '0;
      len_q <= len;
    end else if (en && beat) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done = en & beat & (cnt_q == len_q);
endmodule

// File: rtl/snp_seq_fsm.sv
module snp_seq_fsm
  import snp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic req_write,
  input  logic req_peer,
  input  logic cpu_hitm,
  input  logic wb_done,
  input  logic cpu_busy,
  input  logic burst_done,
  output logic idle,
  output logic dram_busy,
  output logic eads,
  output logic inv_hint,
  output logic boff,
  output logic grant,
  output logic xfer_en
);
  snp_state_e state_q, state_d;
  logic       peer_q;
  logic       wr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      peer_q  <= 1'b0;
      wr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        peer_q <= req_peer;
        wr_q   <= req_write;
      end
    end
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (accept) state_d = req_peer ? ST_GRANT : ST_HOLD;
      ST_HOLD:   state_d = ST_PROBE;
      ST_PROBE:  state_d = ST_GAP;
      ST_GAP:    state_d = ST_SAMPLE;
      ST_SAMPLE: state_d = cpu_hitm ? ST_WBWAIT : ST_GRANT;
      ST_WBWAIT: if (wb_done) state_d = ST_GRANT;
      ST_GRANT:  state_d = ST_XFER;
      ST_XFER:   if (burst_done) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  assign idle      = (state_q == ST_IDLE);
  assign dram_busy = !idle && !peer_q;
  assign eads      = (state_q == ST_PROBE);
  assign inv_hint  = eads & wr_q;
  assign boff      = (state_q == ST_HOLD) & cpu_busy;
  assign grant     = (state_q == ST_GRANT);
  assign xfer_en   = (state_q == ST_XFER);
endmodule

// File: rtl/host_snoop_ctrl.sv
module host_snoop_ctrl #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_peer,
  output logic             grant,
  input  logic             pci_beat,
  input  logic             bridge_hold,
  input  logic             cpu_ads,
  input  logic             cpu_lock,
  input  logic             cpu_busy,
  input  logic             cpu_hitm,
  input  logic             wb_done,
  output logic             ahold,
  output logic             eads,
  output logic             boff,
  output logic             inv_hint
);
  logic lock_block;
  logic accept;
  logic idle;
  logic dram_busy;
  logic xfer_en;
  logic burst_done;

  snp_lock_guard lock_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_ads    (cpu_ads),
    .cpu_lock   (cpu_lock),
    .lock_block (lock_block)
  );

  assign req_ready = idle & ~lock_block & ~bridge_hold;
  assign accept    = req_valid & req_ready;

  snp_beat_count #(.LEN_W(LEN_W)) beats_i (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .len   (req_len),
    .en    (xfer_en),
    .beat  (pci_beat),
    .done  (burst_done)
  );

  snp_seq_fsm fsm_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .req_write  (req_write),
    .req_peer   (req_peer),
    .cpu_hitm   (cpu_hitm),
    .wb_done    (wb_done),
    .cpu_busy   (cpu_busy),
    .burst_done (burst_done),
    .idle       (idle),
    .dram_busy  (dram_busy),
    .eads       (eads),
    .inv_hint   (inv_hint),
    .boff       (boff),
    .grant      (grant),
    .xfer_en    (xfer_en)
  );

  assign ahold = dram_busy | bridge_hold;
endmodule

// File: rtl/snp_checker.sv
module snp_checker (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic req_write,
  input logic grant,
  input logic bridge_hold,
  input logic cpu_ads,
  input logic cpu_lock,
  input logic cpu_hitm,
  input logic wb_done,
  input logic ahold,
  input logic eads,
  input logic boff,
  input logic inv_hint
);
  logic cap_wr, e1_q, e2_q, pend_q, lk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_wr <= 1'b0;
      e1_q   <= 1'b0;
      e2_q   <= 1'b0;
      pend_q <= 1'b0;
      lk_q   <= 1'b0;
    end else begin
      if (req_valid && req_ready) cap_wr <= req_write;
      e1_q <= eads;
      e2_q <= e1_q;
      if (e2_q && cpu_hitm) pend_q <= 1'b1;
      else if (wb_done)     pend_q <= 1'b0;
      if (!cpu_lock)        lk_q <= 1'b0;
      else if (cpu_ads)     lk_q <= 1'b1;
    end
  end

  // R1: no new request while the hold of a previous one is up
  a_r1_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !ahold);
  a_r4_bridge_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bridge_hold |-> (ahold && !req_ready));
  a_r5_eads_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    eads |=> !eads);
  a_r5_eads_held: assert property (@(posedge clk) disable iff (!rst_n)
    eads |-> ahold);
  a_r6_inv_dir: assert property (@(posedge clk) disable iff (!rst_n)
    eads |-> (inv_hint == cap_wr));
  a_r6_inv_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !eads |-> !inv_hint);
  a_r7_wb_first: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> !pend_q);
  a_r8_grant_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> !grant);
  a_r9_lock_block: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_lock && (lk_q || cpu_ads)) |-> !req_ready);
  a_r10_boff_held: assert property (@(posedge clk) disable iff (!rst_n)
    boff |-> (ahold && !eads));
endmodule

bind host_snoop_ctrl snp_checker chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_write   (req_write),
  .grant       (grant),
  .bridge_hold (bridge_hold),
  .cpu_ads     (cpu_ads),
  .cpu_lock    (cpu_lock),
  .cpu_hitm    (cpu_hitm),
  .wb_done     (wb_done),
  .ahold       (ahold),
  .eads        (eads),
  .boff        (boff),
  .inv_hint    (inv_hint)
);

// File: tb/host_snoop_ctrl_tb_top.sv
module host_snoop_ctrl_tb_top;
  localparam int LEN_W = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, req_valid, req_ready, req_write, req_peer, grant, pci_beat;
  logic bridge_hold, cpu_ads, cpu_lock, cpu_busy, cpu_hitm, wb_done;
  logic ahold, eads, boff, inv_hint;
  logic [LEN_W-1:0] req_len;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  host_snoop_ctrl #(.LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_len(req_len), .req_peer(req_peer),
    .grant(grant), .pci_beat(pci_beat), .bridge_hold(bridge_hold),
    .cpu_ads(cpu_ads), .cpu_lock(cpu_lock), .cpu_busy(cpu_busy),
    .cpu_hitm(cpu_hitm), .wb_done(wb_done), .ahold(ahold), .eads(eads),
    .boff(boff), .inv_hint(inv_hint)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected values from the requirements
  function automatic int exp_grant_cycle(bit peer);
    return peer ? 1 : 5;  // R3 / R7
  endfunction
  function automatic int exp_hold(bit peer);
    return peer ? 0 : 1;  // R2 / R3
  endfunction

  task automatic run_req(bit wr, int len, bit peer, bit hitm, bit busy, int wbd, int gap);
    int cyc;
    @(negedge clk);
    chk("R1 ready before request", req_ready, 1);
    req_valid = 1'b1; req_write = wr; req_len = LEN_W'(len); req_peer = peer;
    cpu_busy = busy;
    @(negedge clk);
    cyc = 1;
    req_valid = 1'b0;
    chk("R1 ready low in flight", req_ready, 0);
    if (!peer) begin
      chk("R2 ahold after accept", ahold, 1);
      chk("R10 boff follows busy", boff, busy);
      chk("R5 no strobe yet", eads, 0);
      cpu_busy = 1'b0;
      @(negedge clk); cyc++;
      chk("R5 strobe second cycle", eads, 1);
      chk("R6 hint direction", inv_hint, wr);
      chk("R10 boff only first cycle", boff, 0);
      @(negedge clk); cyc++;
      chk("R5 strobe one cycle", eads, 0);
      chk("R6 hint low off strobe", inv_hint, 0);
      @(negedge clk); cyc++;
      cpu_hitm = hitm;
      chk("R7 no grant while sampling", grant, 0);
      @(negedge clk); cyc++;
      cpu_hitm = 1'b0;
      if (hitm) begin
        for (int i = 0; i < wbd; i++) begin
          chk("R7 grant waits writeback", grant, 0);
          chk("R2 ahold during writeback", ahold, 1);
          @(negedge clk);
        end
        chk("R7 grant waits writeback", grant, 0);
        wb_done = 1'b1;
        @(negedge clk);
        wb_done = 1'b0;
      end else begin
        chk("R7 grant fifth cycle", cyc, exp_grant_cycle(peer));
      end
    end else begin
      chk("R3 peer no hold", ahold, 0);
      chk("R3 peer no strobe", eads, 0);
      chk("R3 peer grant first cycle", cyc, exp_grant_cycle(peer));
      cpu_busy = 1'b0;
    end
    chk("R8 grant pulse", grant, 1);
    chk("R2 hold at grant", ahold, exp_hold(peer));
    @(negedge clk);
    chk("R8 grant one cycle", grant, 0);
    for (int b = 0; b <= len; b++) begin
      for (int g = 0; g < gap; g++) begin
        chk("R2 hold between beats", ahold, exp_hold(peer));
        @(negedge clk);
      end
      chk("R11 burst not done", req_ready, 0);
      chk("R2 hold through burst", ahold, exp_hold(peer));
      pci_beat = 1'b1;
      @(negedge clk);
      pci_beat = 1'b0;
    end
    chk("R11 done after len+1 beats", req_ready, 1);
    chk("R2 hold released", ahold, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_len = '0; req_peer = 1'b0;
    pci_beat = 1'b0; bridge_hold = 1'b0; cpu_ads = 1'b0; cpu_lock = 1'b0;
    cpu_busy = 1'b0; cpu_hitm = 1'b0; wb_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 reset ahold", ahold, 0);
    chk("R12 reset eads", eads, 0);
    chk("R12 reset boff", boff, 0);
    chk("R12 reset inv", inv_hint, 0);
    chk("R12 reset grant", grant, 0);
    chk("R12 reset ready", req_ready, 1);

    // directed corners
    run_req(1'b1, 0, 1'b0, 1'b0, 1'b1, 0, 0);
    run_req(1'b0, 15, 1'b0, 1'b1, 1'b0, 0, 0);
    run_req(1'b1, 2, 1'b0, 1'b1, 1'b1, 3, 1);
    run_req(1'b0, 0, 1'b1, 1'b0, 1'b1, 0, 0);

    // R4 bridge hold window
    @(negedge clk);
    bridge_hold = 1'b1;
    #1;
    chk("R4 ahold with bridge", ahold, 1);
    chk("R4 ready low with bridge", req_ready, 0);
    req_valid = 1'b1; req_peer = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk("R4 no grant with bridge", grant, 0);
      chk("R4 ahold stays", ahold, 1);
    end
    req_valid = 1'b0;
    bridge_hold = 1'b0;
    #1;
    chk("R4 ahold drops", ahold, 0);
    chk("R4 ready back", req_ready, 1);

    // R9 locked sequence
    @(negedge clk);
    cpu_lock = 1'b1;
    #1;
    chk("R9 lock alone no block", req_ready, 1);
    @(negedge clk);
    cpu_ads = 1'b1;
    #1;
    chk("R9 block on lock strobe", req_ready, 0);
    @(negedge clk);
    cpu_ads = 1'b0;
    req_valid = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk("R9 ready low during lock", req_ready, 0);
      chk("R9 no access during lock", ahold, 0);
    end
    req_valid = 1'b0;
    cpu_lock = 1'b0;
    #1;
    chk("R9 ready after unlock", req_ready, 1);

    // constrained random
    for (int n = 0; n < 40; n++) begin
      run_req(1'($urandom % 2), int'($urandom % 5), ($urandom % 4) == 0,
              ($urandom % 3) == 0, 1'($urandom % 2), int'($urandom % 4),
              int'($urandom % 3));
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule